// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a down-counting interval timer behind a small word-addressed register port. Software loads a 32-bit reload value through two 16-bit halves, then starts the counter through the control register. While running, the counter steps down by one on every clock. When it is already at zero it raises a sticky timeout flag, reloads itself from the reload value, and either keeps going (repeating mode) or halts (single-shot mode). A level interrupt follows the timeout flag whenever the interrupt enable is set. Any write to the status register drops the flag.

Two build options change how writes to the reload-value registers behave. With a writable reload value, the written half is stored. With a fixed reload value, the write is not stored, but the counter is still reloaded from the build-time constant. With start/stop control present, a write to either half also halts the counter and the start and stop bits work. Without it, the counter runs from reset, a write to either half leaves it running, and the start and stop bits are ignored.

Top module: `ivl_timer`

## Requirements
- R1: After reset the status reads 0, the control register reads 0, the two halves read back the build-time default reload value, and `irq` is low. With start/stop control present the counter is halted.
- R2: With a writable reload value, word 2 holds the low 16 bits and word 3 the high 16 bits of the reload value, and each reads back what was last written to it.
- R3: A start write takes effect at clock edge E. With reload value P the counter steps down on edges E+1 through E+P, and the timeout flag (status bit 0) becomes set at edge E+P+1, not earlier.
- R4: In repeating mode (control bit 1 = 1) further timeouts fall every P+1 edges after that. In single-shot mode the counter halts at the timeout, so the running indicator (status bit 1) reads 0.
- R5: `irq` is high exactly when the timeout flag is set and the interrupt enable (control bit 0) is 1. Raising the enable over an already set flag raises `irq` in the same cycle as the write.
- R6: A write of any value to word 0 clears the timeout flag. If a timeout happens on the same edge as that write, the flag stays set.
- R7: With start/stop control present, a write to word 2 or word 3 reloads the counter from the new reload value and halts it. A later start counts the full new value.
- R8: A control write with the start bit (bit 2) set does not disturb a counter that is already running. On a halted counter it resumes counting from the value that was held.
- R9: A control write with the stop bit (bit 3) set halts the counter, and stop wins when start and stop are written together.
- R10: With a fixed reload value, writes to words 2 and 3 change nothing that can be read back, yet they reload the counter from the build-time value, so the next timeout comes default+1 edges later.
- R11: Without start/stop control the counter runs from reset. Writes to words 2 and 3 leave it running, and the stop bit has no effect.
- R12: A read strobe returns the addressed word on `bus_rdata` one cycle later, reflecting state before that edge. Start and stop read as 0, and all bits above the defined ones read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_rd | input | 1 | Read strobe; data returns the next cycle |
| bus_addr | input | 2 | Word select: 0 status, 1 control, 2 low half, 3 high half |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Registered read data |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
A register write acts on the clock edge that samples it. The timeout for a counter started on edge E lands on edge E+P+1, and `irq` follows on that same edge with no extra register. Read data is captured on the edge that samples the strobe, and it shows the state from before that edge. The bench drives and samples on falling edges and counts rising edges. Every timing check compares the index of the first falling edge at which `irq` is seen high against an edge index computed from the edge that started the counter.

// File: rtl/ivl_timer_pkg.sv
// Package: shared word selects and bit positions for the interval timer.
// Assumes a four-word register space addressed by a two-bit word index.
package ivl_timer_pkg;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_PLO  = 2'd2,
        SEL_PHI  = 2'd3
    } reg_sel_e;

    // control bit positions
    localparam int CB_IRQEN = 0;
    localparam int CB_CONT  = 1;
    localparam int CB_START = 2;
    localparam int CB_STOP  = 3;

    // status bit positions
    localparam int SB_TMO = 0;
    localparam int SB_RUN = 1;

    typedef struct packed {
        logic stat_wr;
        logic ctrl_wr;
        logic lo_wr;
        logic hi_wr;
    } wr_strobe_t;

endpackage

// File: rtl/ivl_timer_regs.sv
// Module: register port of the interval timer.
// Decodes writes into strobes, holds control bits and the reload value,
// and returns registered read data one cycle after a read strobe.
// Assumes: HALF_W >= 4; DEFAULT_PERIOD fits in 2*HALF_W bits.
module ivl_timer_regs
    import ivl_timer_pkg::*;
#(
    parameter int          HALF_W          = 16,
    parameter int unsigned DEFAULT_PERIOD  = 100,
    parameter bit          PERIOD_WRITABLE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [HALF_W-1:0]   bus_wdata,
    input  logic                timeout_i,
    input  logic                running_i,
    output logic [HALF_W-1:0]   bus_rdata,
    output logic                irq_en_o,
    output logic                cont_o,
    output logic                start_o,
    output logic                stop_o,
    output logic                clear_o,
    output logic                reload_o,
    output logic [2*HALF_W-1:0] period_o,
    output logic [2*HALF_W-1:0] reload_val_o
);
    localparam int                CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0]  DEF_P = CNT_W'(DEFAULT_PERIOD);

    wr_strobe_t          stb;
    logic [CNT_W-1:0]    period_q;
    logic [HALF_W-1:0]   rd_mux;

    // Decode the write strobe into one pulse per register word.
    always_comb begin
        stb         = '0;
        stb.stat_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_STAT);
        stb.ctrl_wr = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);
        stb.lo_wr   = bus_wr && (reg_sel_e'(bus_addr) == SEL_PLO);
        stb.hi_wr   = bus_wr && (reg_sel_e'(bus_addr) == SEL_PHI);
    end

    assign start_o  = stb.ctrl_wr && bus_wdata[CB_START];
    assign stop_o   = stb.ctrl_wr && bus_wdata[CB_STOP];
    assign clear_o  = stb.stat_wr;
    assign reload_o = stb.lo_wr || stb.hi_wr;

    // Hold the interrupt-enable and repeating-mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_o <= 1'b0;
            cont_o   <= 1'b0;
        end else if (stb.ctrl_wr) begin
            irq_en_o <= bus_wdata[CB_IRQEN];
            cont_o   <= bus_wdata[CB_CONT];
        end
    end

    generate
        if (PERIOD_WRITABLE) begin : g_period_rw
            logic [CNT_W-1:0] period_d;

            // Merge a written half into the next reload value.
            always_comb begin
                period_d = period_q;
                if (stb.lo_wr) period_d[HALF_W-1:0]     = bus_wdata;
                if (stb.hi_wr) period_d[CNT_W-1:HALF_W] = bus_wdata;
            end

            // Store the reload value.
            always_ff @(posedge clk) begin
                if (!rst_n) period_q <= DEF_P;
                else        period_q <= period_d;
            end

            assign reload_val_o = period_d;
        end else begin : g_period_fixed
            assign period_q     = DEF_P;
            assign reload_val_o = DEF_P;
        end
    endgenerate

    assign period_o = period_q;

    // Select the addressed word; undefined bits stay zero.
    always_comb begin
        rd_mux = '0;
        case (reg_sel_e'(bus_addr))
            SEL_STAT: begin
                rd_mux[SB_TMO] = timeout_i;
                rd_mux[SB_RUN] = running_i;
            end
            SEL_CTRL: begin
                rd_mux[CB_IRQEN] = irq_en_o;
                rd_mux[CB_CONT]  = cont_o;
            end
            SEL_PLO: rd_mux = period_q[HALF_W-1:0];
            SEL_PHI: rd_mux = period_q[CNT_W-1:HALF_W];
            default: rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/ivl_timer_count.sv
// Module: down counter, run state and timeout flag of the interval timer.
// Steps down while running; at zero it sets the flag and reloads.
// A reload request wins over the terminal reload. A new timeout wins over
// a clear on the same edge. Assumes the request inputs are single-cycle pulses.
module ivl_timer_count #(
    parameter int          CNT_W          = 32,
    parameter int unsigned DEFAULT_PERIOD = 100,
    parameter bit          HAS_START_STOP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             reload_i,
    input  logic             clear_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic             running_o,
    output logic             timeout_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEFAULT_PERIOD);

    logic terminal;

    assign terminal = running_o && (count_o == '0);

    // Step, reload on timeout, or reload on a reload-value write.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_o <= DEF_P;
        else if (reload_i) count_o <= reload_val_i;
        else if (terminal) count_o <= period_i;
        else if (running_o) count_o <= count_o - 1'b1;
    end

    // Sticky timeout flag; setting beats clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)        timeout_o <= 1'b0;
        else if (terminal) timeout_o <= 1'b1;
        else if (clear_i)  timeout_o <= 1'b0;
    end

    generate
        if (HAS_START_STOP) begin : g_ss
            // Run state with start/stop control; stop beats start.
            always_ff @(posedge clk) begin
                if (!rst_n)                    running_o <= 1'b0;
                else if (reload_i || stop_i)   running_o <= 1'b0;
                else if (start_i)              running_o <= 1'b1;
                else if (terminal && !cont_i)  running_o <= 1'b0;
            end
        end else begin : g_free
            // Run state without start/stop control.
            always_ff @(posedge clk) begin
                if (!rst_n)                    running_o <= 1'b1;
                else if (reload_i)             running_o <= 1'b1;
                else if (terminal && !cont_i)  running_o <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/ivl_timer.sv
// Module: top of the interval timer.
// Joins the register port and the counter; irq is the timeout flag gated
// by the interrupt enable, with no register in between.
// Assumes a synchronous active-low reset and a single clock.
module ivl_timer #(
    parameter int          HALF_W          = 16,
    parameter int unsigned DEFAULT_PERIOD  = 100,
    parameter bit          PERIOD_WRITABLE = 1'b1,
    parameter bit          HAS_START_STOP  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic             irq_en, cont, start_p, stop_p, clear_p, reload_p;
    logic             tmo, run;
    logic [CNT_W-1:0] period, reload_val, cnt;

    ivl_timer_regs #(
        .HALF_W          (HALF_W),
        .DEFAULT_PERIOD  (DEFAULT_PERIOD),
        .PERIOD_WRITABLE (PERIOD_WRITABLE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .timeout_i    (tmo),
        .running_i    (run),
        .bus_rdata    (bus_rdata),
        .irq_en_o     (irq_en),
        .cont_o       (cont),
        .start_o      (start_p),
        .stop_o       (stop_p),
        .clear_o      (clear_p),
        .reload_o     (reload_p),
        .period_o     (period),
        .reload_val_o (reload_val)
    );

    ivl_timer_count #(
        .CNT_W          (CNT_W),
        .DEFAULT_PERIOD (DEFAULT_PERIOD),
        .HAS_START_STOP (HAS_START_STOP)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_p),
        .stop_i       (stop_p),
        .reload_i     (reload_p),
        .clear_i      (clear_p),
        .cont_i       (cont),
        .period_i     (period),
        .reload_val_i (reload_val),
        .running_o    (run),
        .timeout_o    (tmo),
        .count_o      (cnt)
    );

    assign irq = tmo && irq_en;

endmodule

// File: rtl/ivl_timer_chk.sv
// Module: assertion checker for the interval timer, bound to the top.
// Relates bus writes, counter state, flag and irq across clock edges.
module ivl_timer_chk
    import ivl_timer_pkg::*;
#(
    parameter int HALF_W         = 16,
    parameter bit HAS_START_STOP = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [1:0]          bus_addr,
    input logic [HALF_W-1:0]   bus_wdata,
    input logic                irq,
    input logic                timeout,
    input logic                running,
    input logic                cont,
    input logic                irq_en,
    input logic [2*HALF_W-1:0] count
);
    localparam int CNT_W = 2 * HALF_W;

    logic period_wr, at_zero;
    assign period_wr = bus_wr && bus_addr[1];
    assign at_zero   = running && (count == '0);

    // R3: a running counter away from zero drops by one per edge
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count != '0 && !period_wr) |=> (count == $past(count) - CNT_W'(1)));

    // R3: the flag only rises after a running counter sat at zero
    p_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(at_zero));

    // R4: single-shot mode halts at the timeout
    p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (at_zero && !cont && !(bus_wr && bus_addr != 2'd0)) |=> !running);

    // R5: no interrupt while disabled
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R6: a status write clears the flag unless a timeout coincides
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !at_zero) |=> !timeout);

    // R7: a reload-value write halts the counter when start/stop exists
    p_period_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_START_STOP && period_wr) |=> !running);

    // R9: stop halts the counter even with start set
    p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_START_STOP && bus_wr && bus_addr == 2'd1 && bus_wdata[CB_STOP]) |=> !running);

    // R11: without start/stop a reload-value write leaves it running
    p_free_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_START_STOP && period_wr) |=> running);

endmodule

bind ivl_timer ivl_timer_chk #(
    .HALF_W         (HALF_W),
    .HAS_START_STOP (HAS_START_STOP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .timeout   (tmo),
    .running   (run),
    .cont      (cont),
    .irq_en    (irq_en),
    .count     (cnt)
);

// File: tb/ivl_timer_tb.sv
// Bench: directed corners plus seeded random reload values and modes.
// Drives and samples on falling edges and counts rising edges in cyc.
module ivl_timer_tb;
    localparam int HW  = 16;
    localparam int FIX = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [HW-1:0] bus_wdata = '0;
    logic [HW-1:0] rdata_a, rdata_b;
    logic          irq_a, irq_b;

    int cyc = 0;
    int checks = 0;
    int errs = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ivl_timer #(.HALF_W(HW), .DEFAULT_PERIOD(100), .PERIOD_WRITABLE(1'b1), .HAS_START_STOP(1'b1))
    u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
           .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a));

    ivl_timer #(.HALF_W(HW), .DEFAULT_PERIOD(FIX), .PERIOD_WRITABLE(1'b0), .HAS_START_STOP(1'b0))
    u_dut_fixed (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // starts and ends on a falling edge; acts on the rising edge between
    task automatic wr(input logic [1:0] a, input logic [HW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int qa, output int qb);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        qa = int'(rdata_a);
        qb = int'(rdata_b);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // first edge index at which irq of the chosen instance is high, or -1
    task automatic first_irq(input bit fixed, input int limit, output int edge_at);
        edge_at = -1;
        for (int i = 0; i < limit; i++) begin
            if ((fixed ? irq_b : irq_a) === 1'b1) begin
                edge_at = cyc;
                return;
            end
            @(negedge clk);
        end
    endtask

    function automatic int next_term(input int w, input int p, input int s);
        int m;
        m = (s - w + p) / (p + 1);
        if (m < 1) m = 1;
        return w + m * (p + 1);
    endfunction

    // halt, clear, load P, then start with the given mode; returns start edge
    task automatic arm(input int p, input bit cont, input bit en, output int w);
        wr(2'd1, 16'h0008);
        wr(2'd0, 16'h0000);
        wr(2'd2, p[HW-1:0]);
        wr(2'd3, 16'h0000);
        wr(2'd1, {12'h0, 1'b0, 1'b1, cont, en});
        w = cyc;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int qa, qb, w, e, p, s, x, y;
        bit c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 free-running from reset
        chk("R1 irq", int'(irq_a), 0);
        rd(2'd0, qa, qb); chk("R1 status", qa, 0); chk("R11 running after reset", qb, 2);
        rd(2'd1, qa, qb); chk("R1 control", qa, 0);
        rd(2'd2, qa, qb); chk("R1 low half", qa, 100); chk("R10 fixed low", qb, FIX);
        rd(2'd3, qa, qb); chk("R1 high half", qa, 0);

        // R12 unused bits and start/stop read as zero
        wr(2'd1, 16'hFFFB);
        rd(2'd1, qa, qb); chk("R12 control readback", qa, 3);
        wr(2'd1, 16'h0000);

        // R2 half readback
        wr(2'd2, 16'hA5C3); wr(2'd3, 16'h1234);
        rd(2'd2, qa, qb); chk("R2 low", qa, 16'hA5C3);
        rd(2'd3, qa, qb); chk("R2 high", qa, 16'h1234);

        // R3/R4/R6 random reload values and modes
        for (int t = 0; t < 24; t++) begin
            p = $urandom_range(1, 40);
            c = 1'($urandom_range(0, 1));
            arm(p, c, 1'b1, w);
            first_irq(1'b0, 80, e); chk("R3 first timeout edge", e, w + p + 1);
            repeat ($urandom_range(0, 12)) @(negedge clk);
            if (c) begin
                wr(2'd0, 16'h0000); s = cyc;
                first_irq(1'b0, 90, e); chk("R4 repeat edge after R6 clear", e, next_term(w, p, s));
            end else begin
                rd(2'd0, qa, qb); chk("R4 one-shot halted", qa, 1);
                wr(2'd0, 16'h5A5A);
                rd(2'd0, qa, qb); chk("R6 flag cleared", qa, 0);
            end
        end

        // R5 flag without enable, then enable raises irq on the write edge
        arm(5, 1'b0, 1'b0, w);
        wait_until(w + 10);
        chk("R5 irq masked", int'(irq_a), 0);
        rd(2'd0, qa, qb); chk("R5 flag set while masked", qa, 1);
        wr(2'd1, 16'h0001);
        chk("R5 irq after enable", int'(irq_a), 1);

        // R8 start on running counter has no effect
        arm(20, 1'b0, 1'b1, w);
        wait_until(w + 3);
        wr(2'd1, 16'h0005);
        first_irq(1'b0, 40, e); chk("R8 start while running", e, w + 21);

        // R8 stop then resume from held count
        arm(20, 1'b0, 1'b1, w);
        wait_until(w + 4); wr(2'd1, 16'h0009); x = cyc;
        wait_until(x + 9); wr(2'd1, 16'h0005); y = cyc;
        first_irq(1'b0, 40, e); chk("R8 resume from held count", e, y + 20 - (x - w) + 1);

        // R9 start and stop together on a running counter
        arm(20, 1'b0, 1'b1, w);
        wr(2'd1, 16'h000D);
        rd(2'd0, qa, qb); chk("R9 stop wins", qa, 0);
        first_irq(1'b0, 40, e); chk("R9 no timeout after stop", e, -1);

        // R7 reload-value write halts and reloads
        arm(20, 1'b0, 1'b1, w);
        wait_until(w + 3);
        wr(2'd2, 16'd10);
        rd(2'd0, qa, qb); chk("R7 halted by write", qa, 0);
        first_irq(1'b0, 30, e); chk("R7 no timeout while halted", e, -1);
        wr(2'd1, 16'h0005); w = cyc;
        first_irq(1'b0, 30, e); chk("R7 full new value", e, w + 11);

        // R6 clear on a timeout edge keeps the flag
        arm(9, 1'b1, 1'b1, w);
        wait_until(w + 19);
        wr(2'd0, 16'h0000);
        chk("R6 timeout beats clear", int'(irq_a), 1);
        wr(2'd0, 16'h0000);
        chk("R6 clear drops irq", int'(irq_a), 0);

        // R10/R11 fixed reload value without start/stop
        wr(2'd1, 16'h000B);
        wr(2'd2, 16'h0033); w = cyc;
        wr(2'd0, 16'h0000);
        first_irq(1'b1, 40, e); chk("R10 reload from fixed value", e, w + FIX + 1);
        rd(2'd2, qa, qb); chk("R10 fixed low unchanged", qb, FIX);
        rd(2'd3, qa, qb); chk("R10 fixed high unchanged", qb, 0);
        wr(2'd1, 16'h0008);
        rd(2'd0, qa, qb); chk("R11 stop ignored", qb & 2, 2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule